// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable synchronous static memory whose bus never idles when it turns from reading to writing or back. On each enabled rising clock edge it registers one command: a read, a write, a deselect, or a burst step. A read returns its word two enabled edges later on `rdata`, qualified by `rvalid`. A write takes its data and its lane enables two enabled edges after its address. Because the data trails the address, the slot after a read never has to be left empty before a write. A write that has been accepted but is not yet visible in the array is forwarded to any read that asks for the same word, so every read sees all writes issued before it.

The read result is a stream with no back-pressure. `rvalid` is the valid half, and there is no ready. A consumer that cannot take a word must hold the whole block through `stall`, which freezes every register, the output included. A command at a new address is loaded when `cont` is low. When `cont` is high, the running burst steps through the other words of its aligned group of four. The step order is either a wrapping increment or an exclusive-or of the count, chosen by `ilv_order`. Three chip selects with mixed polarity gate every new command, and `pwr_down` cancels new work.

Top module: `nwp_sram`

## Requirements
- R1: A read accepted on an enabled edge puts its word on `rdata` with `rvalid` high after the second enabled edge that follows it. Reads and writes may alternate on every edge with no idle slot between them.
- R2: `is_read` low on a load edge makes the command a write. Its data is taken from `wdata`, and its lane enables from `lane_we_n`, on the second enabled edge after the command.
- R3: While `stall` is high, every input is ignored and all state holds. This includes the burst position, the commands in flight, `rdata`, and the registered valid flag.
- R4: A write stores lane i (bits i*LANE_W up to i*LANE_W+LANE_W-1) only when `lane_we_n[i]` is low. Every other lane of that word keeps its old value.
- R5: A read returns the data of every write accepted before it, including a write accepted on the edge just before the read, whose data has not reached the array yet.
- R6: A load starts a read or write only when `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. Any other combination is a deselect: nothing is written and no `rvalid` results.
- R7: With `cont` high, the command repeats the burst's read or write. The upper address bits are kept, and the two low bits become base+n modulo 4 (`ilv_order`=0) or base XOR n (`ilv_order`=1), where n counts the steps modulo 4. `addr`, `is_read` and the selects are ignored.
- R8: A burst step that follows a deselect, or a sleep edge, is itself a deselect.
- R9: `pwr_down` high on an enabled edge turns that edge into a deselect and ends the burst. Commands already in flight still complete.
- R10: `out_en_n` high forces `rvalid` low but does not alter the pipeline. A held word reappears when `out_en_n` returns low.
- R11: While `rst_n` is low, `rvalid` is low and no command is in flight. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| stall | input | 1 | High: ignore inputs, hold all state |
| cont | input | 1 | High: burst step; low: load a new command |
| is_read | input | 1 | On a load: 1 read, 0 write |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| pwr_down | input | 1 | Sleep: current edge becomes a deselect |
| ilv_order | input | 1 | Burst order: 0 wrapping increment, 1 XOR |
| out_en_n | input | 1 | Active-low qualifier for `rvalid` |
| addr | input | ADDR_W | Word address on a load |
| lane_we_n | input | LANES | Active-low lane write enables, taken with write data |
| wdata | input | LANES*LANE_W | Write data, two enabled edges after its command |
| rdata | output | LANES*LANE_W | Read word |
| rvalid | output | 1 | `rdata` holds a read result |

## Verification
A wrong burst counter or a wrong select decode shows at the ports two enabled edges later. The symptom is a read that returns another word, or a `rvalid` pulse that is missing or appears without cause. A stale forwarding register only shows up when a read follows a write to the same word on the very next edge. In that case the first read returns the old lanes, while a read one cycle later returns the correct data, so back-to-back patterns are the ones that expose it. A misapplied lane mask, or a write that commits with the wrong address, stays hidden in the array until that word is next read. For that reason every word is read again after the mask and address sweeps.

// File: rtl/nwp_sram_pkg.sv
package nwp_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low two address bits of burst step n from a base
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] n,
                                           input logic       xor_order);
    return xor_order ? (base ^ n) : (base + n);
  endfunction

endpackage

// File: rtl/nwp_cmd_dec.sv
module nwp_cmd_dec
  import nwp_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cont,
  input  logic              is_read,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              pwr_down,
  input  logic              ilv_order,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q
);

  logic              selected;
  logic [1:0]        step_q;
  logic [1:0]        step_nx;
  logic [ADDR_W-1:0] base_q;

  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign step_nx  = step_q + 2'd1;

  // op_q doubles as the burst's operation: a step repeats it unchanged
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      base_q <= '0;
      step_q <= '0;
    end else if (en) begin
      if (pwr_down) begin
        op_q <= OP_NONE;
      end else if (!cont) begin
        if (selected) begin
          op_q   <= is_read ? OP_RD : OP_WR;
          addr_q <= addr;
          base_q <= addr;
          step_q <= '0;
        end else begin
          op_q <= OP_NONE;
        end
      end else begin
        step_q <= step_nx;
        addr_q <= {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_nx, ilv_order)};
      end
    end
  end

endmodule

// File: rtl/nwp_store.sv
module nwp_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES-1:0]        wr_mask,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en) begin
        if (wr_en && wr_mask[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        if (rd_en) rd_q <= mem[rd_addr];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/nwp_fwd.sv
module nwp_fwd #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] raw,
  output logic [LANES*LANE_W-1:0] merged
);

  logic                    f_vld;
  logic [ADDR_W-1:0]       f_addr;
  logic [LANES*LANE_W-1:0] f_data;
  logic [LANES-1:0]        f_mask;

  // holds the write committed on the same edge the array was read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_vld  <= 1'b0;
      f_addr <= '0;
      f_data <= '0;
      f_mask <= '0;
    end else if (en) begin
      f_vld  <= wr_en;
      f_addr <= wr_addr;
      f_data <= wr_data;
      f_mask <= wr_mask;
    end
  end

  always_comb begin
    merged = raw;
    for (int g = 0; g < LANES; g++) begin
      if (f_vld && f_addr == rd_addr && f_mask[g])
        merged[g*LANE_W +: LANE_W] = f_data[g*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/nwp_sram.sv
module nwp_sram
  import nwp_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic                    cont,
  input  logic                    is_read,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    pwr_down,
  input  logic                    ilv_order,
  input  logic                    out_en_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic              s2_wr;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rdata_q;
  logic              rvld_q;

  assign en    = !stall;
  assign s2_wr = (s2_op == OP_WR);

  nwp_cmd_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cont      (cont),
    .is_read   (is_read),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .pwr_down  (pwr_down),
    .ilv_order (ilv_order),
    .addr      (addr),
    .op_q      (s1_op),
    .addr_q    (s1_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op   <= OP_NONE;
      s2_addr <= '0;
    end else if (en) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
    end
  end

  nwp_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .en      (en),
    .rd_en   (s1_op == OP_RD),
    .rd_addr (s1_addr),
    .wr_en   (s2_wr),
    .wr_addr (s2_addr),
    .wr_data (wdata),
    .wr_mask (~lane_we_n),
    .rd_data (raw)
  );

  nwp_fwd #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_fwd (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .wr_en   (s2_wr),
    .wr_addr (s2_addr),
    .wr_data (wdata),
    .wr_mask (~lane_we_n),
    .rd_addr (s2_addr),
    .raw     (raw),
    .merged  (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q  <= 1'b0;
      rdata_q <= '0;
    end else if (en) begin
      rvld_q <= (s2_op == OP_RD);
      if (s2_op == OP_RD) rdata_q <= merged;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvld_q && !out_en_n;

endmodule

// File: rtl/nwp_sram_chk.sv
module nwp_sram_chk
  import nwp_sram_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              cont,
  input logic              pwr_down,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic [DATA_W-1:0] rdata,
  input op_e               s1_op,
  input op_e               s2_op,
  input logic              rvld_q
);

  a_r3_stall_holds_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(rdata));

  a_r6_partial_select_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !cont && !pwr_down && (sel_a_n || !sel_b || sel_c_n)) |=> (s1_op == OP_NONE));

  a_r9_sleep_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && pwr_down) |=> (s1_op == OP_NONE));

  a_r8_step_after_idle_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && cont && s1_op == OP_NONE) |=> (s1_op == OP_NONE));

  a_r1_read_reaches_output: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && s2_op == OP_RD) |=> rvld_q);

endmodule

bind nwp_sram nwp_sram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .stall    (stall),
  .cont     (cont),
  .pwr_down (pwr_down),
  .sel_a_n  (sel_a_n),
  .sel_b    (sel_b),
  .sel_c_n  (sel_c_n),
  .rdata    (rdata),
  .s1_op    (s1_op),
  .s2_op    (s2_op),
  .rvld_q   (rvld_q)
);

// File: tb/nwp_sram_tb_top.sv
`timescale 1ns/1ps
module nwp_sram_tb_top;

  localparam int AW = 4;
  localparam int NL = 2;
  localparam int LW = 8;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic          cont = 1'b0;
  logic          is_read = 1'b1;
  logic          sel_a_n = 1'b1;
  logic          sel_b = 1'b0;
  logic          sel_c_n = 1'b1;
  logic          pwr_down = 1'b0;
  logic          ilv_order = 1'b0;
  logic          out_en_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] lane_we_n = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #2.5 clk = ~clk;

  nwp_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .cont(cont), .is_read(is_read),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .pwr_down(pwr_down),
    .ilv_order(ilv_order), .out_en_n(out_en_n), .addr(addr),
    .lane_we_n(lane_we_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R11";
  bit    done = 1'b0;

  // reference: 0 none, 1 read, 2 write
  logic [DW-1:0] ref_mem [int];
  int            m1_op = 0, m2_op = 0;
  logic [AW-1:0] m1_addr = '0, m2_addr = '0, base = '0;
  logic [1:0]    cnt = '0;
  logic          exp_vld = 1'b0;
  logic [DW-1:0] exp_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1_op = 0; m2_op = 0; exp_vld = 1'b0;
    end else if (!stall) begin
      exp_vld = (m2_op == 1);
      if (m2_op == 1) exp_data = ref_mem[int'(m2_addr)];
      if (m2_op == 2) begin
        logic [DW-1:0] t;
        t = ref_mem.exists(int'(m2_addr)) ? ref_mem[int'(m2_addr)] : '0;
        for (int b = 0; b < NL; b++)
          if (!lane_we_n[b]) t[b*LW +: LW] = wdata[b*LW +: LW];
        ref_mem[int'(m2_addr)] = t;
      end
      m2_op = m1_op; m2_addr = m1_addr;
      if (pwr_down) m1_op = 0;
      else if (!cont) begin
        if (!sel_a_n && sel_b && !sel_c_n) begin
          m1_op = is_read ? 1 : 2; base = addr; cnt = 2'd0; m1_addr = addr;
        end else m1_op = 0;
      end else begin
        cnt = cnt + 2'd1;
        m1_addr = {base[AW-1:2], ilv_order ? (base[1:0] ^ cnt) : (base[1:0] + cnt)};
      end
    end
  end

  task automatic tick();
    wdata = DW'($urandom);
    @(posedge clk);
    #1;
    checks++;
    if (rvalid !== (exp_vld && !out_en_n)) begin
      errors++;
      $display("FAIL %s rvalid actual=%0b expected=%0b", cur_req, rvalid, exp_vld && !out_en_n);
    end else if (rvalid) begin
      checks++;
      if (rdata !== exp_data) begin
        errors++;
        $display("FAIL %s rdata actual=%h expected=%h", cur_req, rdata, exp_data);
      end
    end
  endtask

  task automatic sel_on(); sel_a_n = 0; sel_b = 1; sel_c_n = 0; endtask

  task automatic op(input bit rd, input int a);
    cont = 0; sel_on(); is_read = rd; addr = AW'(a); tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin cont = 0; sel_a_n = 1; tick(); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cur_req = "R11";
    idle(3);
    rst_n = 1;
    idle(2);

    cur_req = "R1";
    for (int a = 0; a < 16; a++) op(0, a);
    idle(2);
    for (int a = 0; a < 16; a++) op(1, a);
    for (int a = 0; a < 16; a++) begin op(1, a); op(0, a ^ 5); end
    idle(3);

    cur_req = "R4";
    for (int m = 0; m < 4; m++) begin
      lane_we_n = NL'(m);
      for (int a = 0; a < 4; a++) op(0, a);
      idle(2);
      lane_we_n = '0;
      for (int a = 0; a < 4; a++) op(1, a);
      idle(2);
    end

    cur_req = "R5";
    for (int a = 0; a < 16; a++) begin
      lane_we_n = NL'(a);
      op(0, a); op(1, a); op(1, a); op(0, a); op(1, a);
    end
    lane_we_n = '0;
    idle(3);

    cur_req = "R6";
    for (int s = 0; s < 8; s++) begin
      cont = 0; is_read = 0; addr = 4'd9;
      {sel_a_n, sel_b, sel_c_n} = 3'(s); tick();
      idle(2); op(1, 9); op(1, 9);
      cont = 0; is_read = 1; {sel_a_n, sel_b, sel_c_n} = 3'(s); tick();
      idle(3);
    end

    cur_req = "R7";
    for (int il = 0; il < 2; il++)
      for (int b = 0; b < 16; b++)
        for (int rd = 0; rd < 2; rd++) begin
          ilv_order = il[0];
          op(rd[0], b);
          for (int k = 0; k < 5; k++) begin
            cont = 1; is_read = ~rd[0]; sel_a_n = 1; addr = AW'(b + 7); tick();
          end
          idle(2);
        end
    ilv_order = 0;

    cur_req = "R8";
    for (int i = 0; i < 4; i++) begin
      cont = 0; sel_a_n = 1; tick();
      for (int k = 0; k < 3; k++) begin cont = 1; sel_on(); is_read = 0; tick(); end
      op(0, i); cont = 1; pwr_down = 1; tick(); pwr_down = 0;
      for (int k = 0; k < 3; k++) begin cont = 1; tick(); end
      idle(2);
      for (int a = 0; a < 4; a++) op(1, a);
      idle(2);
    end

    cur_req = "R9";
    for (int i = 0; i < 6; i++) begin
      op(1, i); op(0, i + 1);
      pwr_down = 1; op(0, i + 2); op(1, i + 2); pwr_down = 0;
      idle(2); op(1, i + 1); op(1, i + 2); idle(2);
    end

    cur_req = "R3";
    for (int i = 0; i < 600; i++) begin
      stall = ($urandom_range(0, 2) == 0);
      cont = ($urandom_range(0, 3) == 0);
      sel_on(); is_read = $urandom_range(0, 1); addr = AW'($urandom);
      lane_we_n = NL'($urandom); tick();
    end
    stall = 0; lane_we_n = '0; idle(3);

    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      out_en_n = ($urandom_range(0, 2) == 0);
      stall = ($urandom_range(0, 5) == 0);
      cont = ($urandom_range(0, 3) == 0);
      sel_on(); is_read = $urandom_range(0, 1); addr = AW'($urandom); tick();
    end
    out_en_n = 0; stall = 0; idle(3);

    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      stall = ($urandom_range(0, 7) == 0);
      cont = ($urandom_range(0, 2) == 0);
      pwr_down = ($urandom_range(0, 31) == 0);
      ilv_order = $urandom_range(0, 1);
      {sel_a_n, sel_b, sel_c_n} = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b010;
      is_read = $urandom_range(0, 1); addr = AW'($urandom);
      lane_we_n = NL'($urandom); tick();
    end
    stall = 0; pwr_down = 0; lane_we_n = '0; idle(3);
    for (int a = 0; a < 16; a++) op(1, a);
    idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule